// File: doc/BRIEF.md
# Alternate-Space Load/Store Router

This block takes a load or store request tagged with an 8-bit address-space code and sends it to the correct memory-side port. It can send it to the user data port, the supervisor data port or the physical-memory port. It can also complete it locally, either quietly or with a fault. The space code chooses the destination. For the extended physical spaces, the low nibble of the code also becomes physical address bits 35:32.

Before routing, the block resolves the access width and clears the low address bits for that width. A misaligned address with a legal width raises an alignment fault, and no memory request is issued. Load data returned by a port is masked to the access width. It is sign-extended to 64 bits when the request asks for it.

Exactly one request is in flight at a time. The selected port's strobe stays high until that port pulses its done input. One cycle later the block presents the result with a valid strobe. The next request is accepted only after that result has been shown.

Top module: `asi_router`

## Requirements
- R1: After synchronous reset, `req_ready` is 1, `rsp_valid` is 0, all three port strobes are 0 and both fault outputs are 0.
- R2: A size code of 1, 2, 4 or 8 gives that many bytes on `mem_size`, and the low 0, 1, 2 or 3 address bits are cleared on `mem_addr`. Any other size code is handled as 4 bytes, with the low 2 bits cleared and no alignment check.
- R3: Space 0x0A raises `user_req` and space 0x0B raises `sup_req`. In both cases `mem_addr[35:32]` is 0.
- R4: Space 0x20 raises `phys_req` with `mem_addr[35:32]`=0. Spaces 0x21 to 0x2F raise `phys_req` with `mem_addr[35:32]` set to the low nibble of the space code.
- R5: Load data is masked to the access width. When `req_sign` is 1 and the width is 1, 2 or 4 bytes, the top bit of that width is copied into all higher bits. 8-byte data is returned unchanged.
- R6: Spaces 0x0C to 0x0F, 0x30, 0x31, 0x32 and 0x39 raise no strobe and no fault. They complete with `rsp_valid` one cycle after acceptance and `rsp_rdata`=0.
- R7: Every other space code, 0x08 included, raises no strobe. It completes one cycle after acceptance with `rsp_rdata`=0 and a one-cycle `fault_unassigned` pulse. During that pulse, `fault_addr` holds the request address, `fault_write` holds the direction (1 = store) and `fault_space` holds the space code.
- R8: A size code of 2, 4 or 8 with a misaligned address raises no strobe. It completes one cycle after acceptance with a one-cycle `fault_align` pulse and `rsp_rdata`=0, and `fault_unassigned` stays 0 whatever the space code is.
- R9: A port strobe and `mem_addr` stay constant until that port's done input is seen. `rsp_valid` is high for exactly the cycle after that done. `req_ready` is 0 from acceptance through the `rsp_valid` cycle.
- R10: A done pulse from a port that is not selected is ignored. The strobe stays high and no response is produced.
- R11: A store drives `mem_we`=1 and passes `req_wdata` to `mem_wdata`. Its response has `rsp_rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Request address |
| req_space | input | 8 | Address-space code |
| req_size | input | 4 | Access size in bytes (1, 2, 4, 8) |
| req_sign | input | 1 | Sign-extend load data |
| req_write | input | 1 | 1 = store, 0 = load |
| req_wdata | input | 64 | Store data |
| user_req | output | 1 | User data port strobe |
| sup_req | output | 1 | Supervisor data port strobe |
| phys_req | output | 1 | Physical port strobe |
| mem_addr | output | 36 | Aligned address for the selected port |
| mem_we | output | 1 | Store direction to ports |
| mem_size | output | 4 | Effective access size in bytes |
| mem_wdata | output | 64 | Store data to ports |
| user_done | input | 1 | User port completion pulse |
| user_rdata | input | 64 | User port read data |
| sup_done | input | 1 | Supervisor port completion pulse |
| sup_rdata | input | 64 | Supervisor port read data |
| phys_done | input | 1 | Physical port completion pulse |
| phys_rdata | input | 64 | Physical port read data |
| rsp_valid | output | 1 | Result strobe |
| rsp_rdata | output | 64 | Load result (zero for stores and local completions) |
| fault_align | output | 1 | Alignment fault pulse |
| fault_unassigned | output | 1 | Unassigned-space fault pulse |
| fault_addr | output | 32 | Faulting request address |
| fault_write | output | 1 | Faulting request direction |
| fault_space | output | 8 | Faulting space code |

## Verification
The hardest situation to reach from the ports is a done pulse that arrives from a port other than the one holding a request. A well-behaved memory model never produces it. For this case the bench's memory responder first pulses a foreign port's done while a user-port load waits. It then confirms that the strobe is still held and that no response has appeared, and only after that answers from the correct port. The other corners are the interaction of the alignment check with the space code, and unrecognised size codes that skip the check. Two sweeps cover them: one crosses every size code with every low-address offset, and one crosses all 256 space codes.

// File: rtl/asi_pkg.sv
package asi_pkg;
  // Route outcome of one request; the first three values double as port indices.
  typedef enum logic [2:0] {
    RT_USER  = 3'd0,
    RT_SUP   = 3'd1,
    RT_PHYS  = 3'd2,
    RT_QUIET = 3'd3,
    RT_UNASG = 3'd4,
    RT_MISAL = 3'd5
  } route_e;

  localparam int NPORT = 3;

  typedef enum logic {S_IDLE, S_WAIT} state_e;
endpackage

// File: rtl/asi_decode.sv
module asi_decode
  import asi_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int SPACE_W = 8,
  parameter int EXT_W   = 4,
  parameter int SIZE_W  = 4
) (
  input  logic [ADDR_W-1:0]       addr,
  input  logic [SPACE_W-1:0]      space,
  input  logic [SIZE_W-1:0]       size,
  output route_e                  route,
  output logic [SIZE_W-1:0]       eff_size,
  output logic [ADDR_W+EXT_W-1:0] out_addr
);
  logic              known;
  logic [ADDR_W-1:0] low_mask;
  logic [EXT_W-1:0]  ext;
  logic              misal;

  // Width resolution and alignment
  always_comb begin
    known    = 1'b1;
    eff_size = size;
    case (size)
      SIZE_W'(1), SIZE_W'(2), SIZE_W'(4), SIZE_W'(8): known = 1'b1;
      default: begin
        known    = 1'b0;
        eff_size = SIZE_W'(4);
      end
    endcase
    low_mask = ADDR_W'(eff_size) - ADDR_W'(1);
    misal    = known && ((addr & low_mask) != '0);
  end

  // Space classification
  always_comb begin
    ext   = '0;
    route = RT_UNASG;
    if (space == SPACE_W'('h0A))
      route = RT_USER;
    else if (space == SPACE_W'('h0B))
      route = RT_SUP;
    else if (space == SPACE_W'('h20))
      route = RT_PHYS;
    else if ((space >> 4) == SPACE_W'(2)) begin
      route = RT_PHYS;
      ext   = space[EXT_W-1:0];
    end else if ((space >= SPACE_W'('h0C) && space <= SPACE_W'('h0F)) ||
               (space >= SPACE_W'('h30) && space <= SPACE_W'('h32)) ||
               space == SPACE_W'('h39))
      route = RT_QUIET;
    if (misal)
      route = RT_MISAL;
    out_addr = {ext, addr & ~low_mask};
  end

  // R2: the emitted byte address is a multiple of the resolved width
  always_comb begin
    a_r2_out_aligned: assert ((32'(out_addr[ADDR_W-1:0]) % 32'(eff_size)) == 0);
  end
endmodule

// File: rtl/asi_extend.sv
module asi_extend #(
  parameter int DATA_W = 64,
  parameter int SIZE_W = 4
) (
  input  logic [DATA_W-1:0] din,
  input  logic [SIZE_W-1:0] size,
  input  logic              sign,
  output logic [DATA_W-1:0] dout
);
  // Mask to the access width, then optionally replicate its top bit.
  always_comb begin
    case (size)
      SIZE_W'(1): dout = {{(DATA_W-8){sign & din[7]}},   din[7:0]};
      SIZE_W'(2): dout = {{(DATA_W-16){sign & din[15]}}, din[15:0]};
      SIZE_W'(4): dout = {{(DATA_W-32){sign & din[31]}}, din[31:0]};
      default:    dout = din;
    endcase
  end
endmodule

// File: rtl/asi_router.sv
module asi_router
  import asi_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int SPACE_W = 8,
  parameter int EXT_W   = 4,
  parameter int SIZE_W  = 4,
  parameter int DATA_W  = 64
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [SPACE_W-1:0]      req_space,
  input  logic [SIZE_W-1:0]       req_size,
  input  logic                    req_sign,
  input  logic                    req_write,
  input  logic [DATA_W-1:0]       req_wdata,
  output logic                    user_req,
  output logic                    sup_req,
  output logic                    phys_req,
  output logic [ADDR_W+EXT_W-1:0] mem_addr,
  output logic                    mem_we,
  output logic [SIZE_W-1:0]       mem_size,
  output logic [DATA_W-1:0]       mem_wdata,
  input  logic                    user_done,
  input  logic [DATA_W-1:0]       user_rdata,
  input  logic                    sup_done,
  input  logic [DATA_W-1:0]       sup_rdata,
  input  logic                    phys_done,
  input  logic [DATA_W-1:0]       phys_rdata,
  output logic                    rsp_valid,
  output logic [DATA_W-1:0]       rsp_rdata,
  output logic                    fault_align,
  output logic                    fault_unassigned,
  output logic [ADDR_W-1:0]       fault_addr,
  output logic                    fault_write,
  output logic [SPACE_W-1:0]      fault_space
);
  localparam int PADDR_W = ADDR_W + EXT_W;

  state_e                  state;
  route_e                  dec_route;
  logic [SIZE_W-1:0]       dec_size;
  logic [PADDR_W-1:0]      dec_addr;
  logic [NPORT-1:0]        sel;
  logic [NPORT-1:0]        done_v;
  logic [DATA_W-1:0]       rdata_v [NPORT];
  logic [DATA_W-1:0]       rdata_mux;
  logic [DATA_W-1:0]       ext_data;
  logic                    pend_sign;
  logic                    accept;
  logic                    done_sel;
  logic                    to_port;

  asi_decode #(
    .ADDR_W (ADDR_W),
    .SPACE_W(SPACE_W),
    .EXT_W  (EXT_W),
    .SIZE_W (SIZE_W)
  ) u_decode (
    .addr    (req_addr),
    .space   (req_space),
    .size    (req_size),
    .route   (dec_route),
    .eff_size(dec_size),
    .out_addr(dec_addr)
  );

  assign done_v  = {phys_done, sup_done, user_done};
  assign rdata_v[0] = user_rdata;
  assign rdata_v[1] = sup_rdata;
  assign rdata_v[2] = phys_rdata;

  assign req_ready = (state == S_IDLE) && !rsp_valid;
  assign accept    = req_valid && req_ready;
  assign to_port   = (dec_route == RT_USER) || (dec_route == RT_SUP) || (dec_route == RT_PHYS);
  assign done_sel  = |(done_v & sel);

  // Read-data selection from the one held port
  always_comb begin
    rdata_mux = '0;
    for (int i = 0; i < NPORT; i++)
      if (sel[i]) rdata_mux = rdata_v[i];
  end

  asi_extend #(
    .DATA_W(DATA_W),
    .SIZE_W(SIZE_W)
  ) u_extend (
    .din (rdata_mux),
    .size(mem_size),
    .sign(pend_sign),
    .dout(ext_data)
  );

  // Per-port strobe: set on acceptance, held until that port's own done
  for (genvar g = 0; g < NPORT; g++) begin : g_port
    always_ff @(posedge clk) begin
      if (rst)
        sel[g] <= 1'b0;
      else if (accept && dec_route == route_e'(3'(g)))
        sel[g] <= 1'b1;
      else if (state == S_WAIT && sel[g] && done_v[g])
        sel[g] <= 1'b0;
    end
  end

  assign user_req = sel[0];
  assign sup_req  = sel[1];
  assign phys_req = sel[2];

  // Request capture, completion and fault reporting
  always_ff @(posedge clk) begin
    if (rst) begin
      state            <= S_IDLE;
      mem_addr         <= '0;
      mem_we           <= 1'b0;
      mem_size         <= '0;
      mem_wdata        <= '0;
      pend_sign        <= 1'b0;
      rsp_valid        <= 1'b0;
      rsp_rdata        <= '0;
      fault_align      <= 1'b0;
      fault_unassigned <= 1'b0;
      fault_addr       <= '0;
      fault_write      <= 1'b0;
      fault_space      <= '0;
    end else begin
      rsp_valid        <= 1'b0;
      fault_align      <= 1'b0;
      fault_unassigned <= 1'b0;
      case (state)
        S_IDLE: begin
          if (accept) begin
            mem_addr  <= dec_addr;
            mem_we    <= req_write;
            mem_size  <= dec_size;
            mem_wdata <= req_write ? req_wdata : '0;
            pend_sign <= req_sign && !req_write;
            if (to_port) begin
              state <= S_WAIT;
            end else begin
              rsp_valid        <= 1'b1;
              rsp_rdata        <= '0;
              fault_align      <= (dec_route == RT_MISAL);
              fault_unassigned <= (dec_route == RT_UNASG);
              fault_addr       <= req_addr;
              fault_write      <= req_write;
              fault_space      <= req_space;
            end
          end
        end
        S_WAIT: begin
          if (done_sel) begin
            state     <= S_IDLE;
            rsp_valid <= 1'b1;
            rsp_rdata <= mem_we ? '0 : ext_data;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // Assertions
  a_r9_one_port: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel));
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (|sel && !done_sel) |=> ($stable(sel) && $stable(mem_addr)));
  a_r9_busy: assert property (@(posedge clk) disable iff (rst)
    (|sel || rsp_valid) |-> !req_ready);
  a_r9_rsp_after_done: assert property (@(posedge clk) disable iff (rst)
    (|sel && done_sel) |=> (rsp_valid && !(|sel)));
  a_r7_pulse: assert property (@(posedge clk) disable iff (rst)
    fault_unassigned |=> !fault_unassigned);
  a_r8_pulse: assert property (@(posedge clk) disable iff (rst)
    fault_align |=> !fault_align);
  a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(fault_align && fault_unassigned));
  a_r7_fault_zero: assert property (@(posedge clk) disable iff (rst)
    (fault_align || fault_unassigned) |-> (rsp_valid && rsp_rdata == '0 && !(|sel)));
  a_r11_store_zero: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && mem_we) |-> (rsp_rdata == '0));
  a_r3_no_ext: assert property (@(posedge clk) disable iff (rst)
    (user_req || sup_req) |-> (mem_addr[PADDR_W-1:ADDR_W] == '0));
  a_r2_port_aligned: assert property (@(posedge clk) disable iff (rst)
    (|sel) |-> ((mem_addr[ADDR_W-1:0] & (ADDR_W'(mem_size) - ADDR_W'(1))) == '0));
endmodule

// File: tb/asi_router_tb.sv
module asi_router_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [7:0]  req_space = '0;
  logic [3:0]  req_size = '0;
  logic        req_sign = 1'b0;
  logic        req_write = 1'b0;
  logic [63:0] req_wdata = '0;
  logic        user_req, sup_req, phys_req;
  logic [35:0] mem_addr;
  logic        mem_we;
  logic [3:0]  mem_size;
  logic [63:0] mem_wdata;
  logic        user_done = 1'b0, sup_done = 1'b0, phys_done = 1'b0;
  logic [63:0] user_rdata = '0, sup_rdata = '0, phys_rdata = '0;
  logic        rsp_valid;
  logic [63:0] rsp_rdata;
  logic        fault_align, fault_unassigned;
  logic [31:0] fault_addr;
  logic        fault_write;
  logic [7:0]  fault_space;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  asi_router u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_space(req_space), .req_size(req_size),
    .req_sign(req_sign), .req_write(req_write), .req_wdata(req_wdata),
    .user_req(user_req), .sup_req(sup_req), .phys_req(phys_req),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_size(mem_size), .mem_wdata(mem_wdata),
    .user_done(user_done), .user_rdata(user_rdata),
    .sup_done(sup_done), .sup_rdata(sup_rdata),
    .phys_done(phys_done), .phys_rdata(phys_rdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .fault_align(fault_align), .fault_unassigned(fault_unassigned),
    .fault_addr(fault_addr), .fault_write(fault_write), .fault_space(fault_space)
  );

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Reference model: 0 user, 1 sup, 2 phys, 3 quiet, 4 unassigned, 5 misaligned
  function automatic int model_route(input logic [7:0] sp, input int sz, input logic [31:0] a);
    bit known = (sz == 1 || sz == 2 || sz == 4 || sz == 8);
    int n = known ? sz : 4;
    if (known && (a % n) != 0) return 5;
    if (sp == 8'h0A) return 0;
    if (sp == 8'h0B) return 1;
    if (sp >= 8'h20 && sp <= 8'h2F) return 2;
    if ((sp >= 8'h0C && sp <= 8'h0F) || (sp >= 8'h30 && sp <= 8'h32) || sp == 8'h39) return 3;
    return 4;
  endfunction

  function automatic logic [63:0] model_ext(input logic [63:0] d, input int n, input bit s);
    logic [63:0] m;
    logic [63:0] v;
    m = (n == 8) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8*n)) - 64'd1);
    v = d & m;
    if (s && n < 8 && d[8*n-1]) v = v | ~m;
    return v;
  endfunction

  // Issue one request, act as the memory side, and check the outcome.
  task automatic run(input logic [31:0] a, input logic [7:0] sp, input int sz,
                     input bit s, input bit w, input logic [63:0] wd,
                     input logic [63:0] rd, input bit foreign_first, input string tag);
    int   rt = model_route(sp, sz, a);
    bit   known = (sz == 1 || sz == 2 || sz == 4 || sz == 8);
    int   n = known ? sz : 4;
    logic [35:0] ea;
    logic [63:0] er;
    int   got_port = -1;
    bit   got_rsp = 1'b0;
    logic [63:0] r_data = '0;
    logic f_al = 1'b0, f_un = 1'b0, f_w = 1'b0;
    logic [31:0] f_a = '0;
    logic [7:0]  f_s = '0;
    ea = {(sp >= 8'h21 && sp <= 8'h2F) ? sp[3:0] : 4'h0, a & ~(32'(n) - 32'd1)};
    er = (w || rt > 2) ? 64'd0 : model_ext(rd, n, s);
    while (!req_ready) @(negedge clk);
    req_addr = a; req_space = sp; req_size = 4'(sz); req_sign = s;
    req_write = w; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 12 && !got_rsp; k++) begin
      if (rsp_valid) begin
        got_rsp = 1'b1;
        r_data = rsp_rdata; f_al = fault_align; f_un = fault_unassigned;
        f_w = fault_write; f_a = fault_addr; f_s = fault_space;
        chk("R9", "ready low in rsp cycle", 64'(req_ready), 64'd0);
      end else if (user_req || sup_req || phys_req) begin
        got_port = user_req ? 0 : (sup_req ? 1 : 2);
        chk("R9", "ready low while held", 64'(req_ready), 64'd0);
        chk(tag, "mem_addr", 64'(mem_addr), 64'(ea));
        chk("R2", "mem_size", 64'(mem_size), 64'(n));
        chk("R11", "mem_we", 64'(mem_we), 64'(w));
        if (w) chk("R11", "mem_wdata", mem_wdata, wd);
        if (foreign_first) begin
          if (got_port == 0) sup_done = 1'b1; else user_done = 1'b1;
          user_rdata = 64'hDEAD_BEEF_DEAD_BEEF; sup_rdata = 64'hDEAD_BEEF_DEAD_BEEF;
          @(negedge clk);
          user_done = 1'b0; sup_done = 1'b0;
          chk("R10", "strobe kept after foreign done", 64'({phys_req, sup_req, user_req}), 64'(1 << got_port));
          chk("R10", "no response on foreign done", 64'(rsp_valid), 64'd0);
          @(negedge clk);
          chk("R9", "strobe still held", 64'({phys_req, sup_req, user_req}), 64'(1 << got_port));
        end
        case (got_port)
          0: begin user_rdata = rd; user_done = 1'b1; end
          1: begin sup_rdata = rd; sup_done = 1'b1; end
          default: begin phys_rdata = rd; phys_done = 1'b1; end
        endcase
        @(negedge clk);
        user_done = 1'b0; sup_done = 1'b0; phys_done = 1'b0;
        user_rdata = '0; sup_rdata = '0; phys_rdata = '0;
        chk("R9", "rsp one cycle after done", 64'(rsp_valid), 64'd1);
      end else begin
        @(negedge clk);
      end
    end
    if (!got_rsp) begin
      errors++; checks++;
      $display("FAIL R9 no response: actual=0 expected=1");
      return;
    end
    chk(tag, "port", 64'(got_port), (rt <= 2) ? 64'(rt) : 64'hFFFF_FFFF_FFFF_FFFF);
    chk((rt == 5) ? "R8" : (w ? "R11" : "R5"), "rsp_rdata", r_data, er);
    chk("R8", "fault_align", 64'(f_al), 64'(rt == 5));
    chk("R7", "fault_unassigned", 64'(f_un), 64'(rt == 4));
    if (rt >= 4) begin
      chk("R7", "fault_addr", 64'(f_a), 64'(a));
      chk("R7", "fault_write", 64'(f_w), 64'(w));
      chk("R7", "fault_space", 64'(f_s), 64'(sp));
    end
    @(negedge clk);
    chk("R9", "rsp single cycle", 64'(rsp_valid), 64'd0);
    chk("R7", "faults single cycle", 64'({fault_align, fault_unassigned}), 64'd0);
    chk("R9", "ready back", 64'(req_ready), 64'd1);
  endtask

  initial begin
    while (cycles < WATCHDOG) @(posedge clk) cycles++;
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected<%0d cycles", cycles, WATCHDOG);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1", "req_ready", 64'(req_ready), 64'd1);
    chk("R1", "rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1", "strobes", 64'({user_req, sup_req, phys_req}), 64'd0);
    chk("R1", "faults", 64'({fault_align, fault_unassigned}), 64'd0);

    // All space codes, signed 4-byte load: R3 R4 R6 R7
    for (int sp = 0; sp < 256; sp++)
      run(32'h1234_5678, 8'(sp), 4, 1'b1, 1'b0, 64'd0, 64'h0123_4567_8765_4321, 1'b0,
          (sp == 8'h0A || sp == 8'h0B) ? "R3" : ((sp >= 8'h20 && sp <= 8'h2F) ? "R4" : "R6"));

    // Every size code x low offset x sign, on user and physical spaces: R2 R5 R8
    for (int sz = 0; sz < 16; sz++)
      for (int off = 0; off < 8; off++)
        for (int s = 0; s < 2; s++)
          run(32'hA000_0100 | 32'(off), (off[0]) ? 8'h20 : 8'h0A, sz, s[0], 1'b0, 64'd0,
              64'hF0E1_D2C3_B4A5_9687, 1'b0, "R2");

    // Misaligned on an unassigned space: alignment wins (R8)
    run(32'h0000_0003, 8'h08, 4, 1'b0, 1'b0, 64'd0, 64'd0, 1'b0, "R8");
    run(32'h0000_0006, 8'h77, 8, 1'b0, 1'b1, 64'h1, 64'd0, 1'b0, "R8");

    // Stores to extended physical spaces and supervisor: R4 R11
    for (int sp = 8'h21; sp <= 8'h2F; sp++)
      run(32'h8000_0010, 8'(sp), 8, 1'b0, 1'b1, {32'hCAFE_0000 | 32'(sp), 32'h5555_AAAA},
          64'hFFFF_FFFF_FFFF_FFFF, 1'b0, "R4");
    run(32'h4000_0020, 8'h0B, 2, 1'b1, 1'b1, 64'h0000_0000_0000_8001, 64'hFFFF, 1'b0, "R11");

    // Store to code-access space 8 and to a quiet space: R7 R6
    run(32'h0000_1000, 8'h08, 4, 1'b0, 1'b1, 64'h99, 64'd0, 1'b0, "R7");
    run(32'h0000_1000, 8'h39, 4, 1'b0, 1'b1, 64'h99, 64'd0, 1'b0, "R6");

    // Foreign done pulses ignored: R10
    run(32'h0000_2008, 8'h0A, 8, 1'b0, 1'b0, 64'h1122_3344_5566_7788, 64'h1122_3344_5566_7788, 1'b1, "R10");
    run(32'h0000_2004, 8'h0B, 1, 1'b1, 1'b0, 64'd0, 64'h0000_0000_0000_0080, 1'b1, "R10");
    run(32'h0000_2004, 8'h25, 4, 1'b1, 1'b0, 64'd0, 64'h0000_0000_7FFF_FFFF, 1'b1, "R10");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule